// File: doc/BRIEF.md
# Accumulator ALU with Flag Update

This block is the arithmetic, logic and flag-update stage of a small 8-bit accumulator processor. Each cycle in which `op_valid` is high it takes a 5-bit operation code, two data operands and the current 8-bit flags byte. One clock later it presents the result byte and the new flags byte, with `res_valid` high for exactly that cycle. The flags byte holds interrupt enable (bit 0), Zero (bit 1), Carry (bit 2), Supervisor (bit 3) and register-bank select (bit 4). Bits 7:5 are reserved and always leave the block as 0.

Each operation writes only the flags it owns and passes the others through from `flags_in`. Three operations act on the flags byte itself. For these, `opnd_b` serves as a mask, and the Supervisor bit cannot be changed by them. Instruction fetch, decode, addressing and memory belong to the surrounding processor.

Top module: `acc_alu_core`

## Requirements
- R1: After reset `res_out`, `flags_out` and `res_valid` are all 0. An operation presented with `op_valid` high appears on `res_out`/`flags_out` after the next rising edge, with `res_valid` high for that one cycle only.
- R2: Opcode 0 (add) gives `a+b` and opcode 1 (add with carry) gives `a+b+C`, where C is `flags_in` bit 2. The output Carry is the carry out of bit 7, and Zero is set when the 8-bit result is 0.
- R3: Opcode 2 (subtract) gives `a-b` and opcode 3 (subtract with borrow) gives `a-b-C`. Carry is set when the true difference is negative (unsigned borrow), and Zero reflects the result.
- R4: Opcodes 4, 5 and 6 give `a&b`, `a|b` and `a^b`. They set Zero from the result and pass Carry through unchanged.
- R5: Opcode 7 (compare) returns `a` unchanged, sets Zero when `a==b` and sets Carry when `a<b` unsigned. Opcode 8 (test) returns `a` unchanged, sets Zero when `a&b` is 0 and keeps Carry.
- R6: Opcode 9 (complement) gives `~a` and opcode 15 (move) gives `b`; both update only Zero. Opcode 10 (increment) gives `a+1`, sets Carry when `a` was 0xFF, and sets Zero from the result.
- R7: Opcode 11 shifts left, filling bit 0 with 0 and moving bit 7 to Carry. Opcode 12 shifts right, keeping bit 7 and moving bit 0 to Carry. Opcode 13 rotates left through Carry (old Carry to bit 0, bit 7 to Carry). Opcode 14 rotates right through Carry (old Carry to bit 7, bit 0 to Carry). All four set Zero from the result.
- R8: Opcodes 16, 17 and 18 return `a` unchanged and set the new flags to `flags_in` AND, OR or XOR `opnd_b` respectively. Bit 3 keeps its `flags_in` value, and bits 7:5 are 0.
- R9: For every opcode other than 16 to 18, `flags_out` bits 0, 3 and 4 equal the `flags_in` bits, and bits 7:5 are 0. Opcodes 19 to 31 return `a` and change no flag.
- R10: While `op_valid` is low, `res_out` and `flags_out` hold their last values whatever the other inputs do, and `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation select (encoding in R2 to R9) |
| opnd_a | input | 8 | First operand (accumulator side) |
| opnd_b | input | 8 | Second operand, or mask for flag operations |
| flags_in | input | 8 | Current flags byte |
| res_out | output | 8 | Registered result |
| flags_out | output | 8 | Registered new flags byte |
| res_valid | output | 1 | Result and flags updated this cycle |

## Verification
A wrong carry chain, borrow sense or shift fill shows in `res_out` or in bit 2 of `flags_out` in the cycle straight after the operation. A flag the operation should not touch but does shows in the same cycle as a difference from `flags_in`. This is most telling for Carry under the logic operations and for the Supervisor bit under the flag-byte operations. Carry-in dependent operations (add with carry, subtract with borrow, rotates) are driven with both values of the incoming Carry. The 0x00/0xFF operand edges are covered so that Zero and Carry boundaries are hit, and held state is compared after idle cycles with changing inputs.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DW      = 8;
    localparam int FW      = 8;
    localparam int OPW     = 5;

    localparam int FL_GIE   = 0;
    localparam int FL_ZERO  = 1;
    localparam int FL_CARRY = 2;
    localparam int FL_SUPER = 3;
    localparam int FL_BANK  = 4;
    localparam int FL_USED  = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBB  = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_CMP  = 5'd7,
        OP_TST  = 5'd8,
        OP_CPL  = 5'd9,
        OP_INC  = 5'd10,
        OP_ASL  = 5'd11,
        OP_ASR  = 5'd12,
        OP_RLC  = 5'd13,
        OP_RRC  = 5'd14,
        OP_MOV  = 5'd15,
        OP_FAND = 5'd16,
        OP_FOR  = 5'd17,
        OP_FXOR = 5'd18
    } alu_op_e;

    typedef enum logic [1:0] {
        BW_AND = 2'd0,
        BW_OR  = 2'd1,
        BW_XOR = 2'd2,
        BW_NOT = 2'd3
    } bw_sel_e;

    typedef enum logic [1:0] {
        SH_ASL = 2'd0,
        SH_ASR = 2'd1,
        SH_RLC = 2'd2,
        SH_RRC = 2'd3
    } sh_sel_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int SW = W + 1;

    logic [SW-1:0] full;
    logic [W-1:0]  b_eff;
    logic          c_eff;

    // Subtraction as a + ~b + ~borrow; carry out inverted into a borrow flag.
    always_comb begin
        b_eff = sub ? ~b : b;
        c_eff = sub ? ~cin : cin;
        full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        sum   = full[W-1:0];
        cout  = sub ? ~full[W] : full[W];
    end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  bw_sel_e      sel,
    output logic [W-1:0] y
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            case (sel)
                BW_AND:  y[i] = a[i] & b[i];
                BW_OR:   y[i] = a[i] | b[i];
                BW_XOR:  y[i] = a[i] ^ b[i];
                default: y[i] = ~a[i];
            endcase
        end
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    input  sh_sel_e      sel,
    output logic [W-1:0] y,
    output logic         cout
);
    localparam int MSB = W - 1;

    always_comb begin
        case (sel)
            SH_ASL: begin
                y    = {a[MSB-1:0], 1'b0};
                cout = a[MSB];
            end
            SH_ASR: begin
                y    = {a[MSB], a[MSB:1]};
                cout = a[0];
            end
            SH_RLC: begin
                y    = {a[MSB-1:0], cin};
                cout = a[MSB];
            end
            default: begin
                y    = {cin, a[MSB:1]};
                cout = a[0];
            end
        endcase
    end
endmodule

// File: rtl/alu_flag_logic.sv
module alu_flag_logic
    import acc_alu_pkg::*;
(
    input  logic [FW-1:0] flags,
    input  logic [FW-1:0] mask,
    input  bw_sel_e       sel,
    output logic [FW-1:0] y
);
    logic [FW-1:0] raw;

    alu_bitwise #(.W(FW)) i_bw (
        .a   (flags),
        .b   (mask),
        .sel (sel),
        .y   (raw)
    );

    // Supervisor is not writable here; reserved bits read as zero.
    always_comb begin
        y           = raw;
        y[FL_SUPER] = flags[FL_SUPER];
        y[FW-1:FL_USED] = '0;
    end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int W = DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [OPW-1:0] op_code,
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    input  logic [FW-1:0] flags_in,
    output logic [W-1:0]  res_out,
    output logic [FW-1:0] flags_out,
    output logic          res_valid
);
    typedef struct packed {
        logic [W-1:0]  res;
        logic [FW-1:0] flg;
        logic          vld;
    } core_state_t;

    core_state_t st_d, st_q;
    alu_op_e     op;

    // adder controls and outputs
    logic [W-1:0] as_b;
    logic         as_cin, as_sub, as_cout;
    logic [W-1:0] as_sum;

    // bitwise unit
    bw_sel_e      bw_sel;
    logic [W-1:0] bw_y;

    // shifter
    sh_sel_e      sh_sel;
    logic [W-1:0] sh_y;
    logic         sh_cout;

    // flag-byte logic
    bw_sel_e       fl_sel;
    logic [FW-1:0] fl_y;

    logic c_in;

    assign op   = alu_op_e'(op_code);
    assign c_in = flags_in[FL_CARRY];

    always_comb begin
        as_b   = opnd_b;
        as_cin = 1'b0;
        as_sub = 1'b0;
        case (op)
            OP_ADC:         as_cin = c_in;
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBB: begin
                as_sub = 1'b1;
                as_cin = c_in;
            end
            OP_INC: begin
                as_b   = '0;
                as_cin = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        case (op)
            OP_OR:   bw_sel = BW_OR;
            OP_XOR:  bw_sel = BW_XOR;
            OP_CPL:  bw_sel = BW_NOT;
            default: bw_sel = BW_AND;
        endcase
        case (op)
            OP_ASR:  sh_sel = SH_ASR;
            OP_RLC:  sh_sel = SH_RLC;
            OP_RRC:  sh_sel = SH_RRC;
            default: sh_sel = SH_ASL;
        endcase
        case (op)
            OP_FOR:  fl_sel = BW_OR;
            OP_FXOR: fl_sel = BW_XOR;
            default: fl_sel = BW_AND;
        endcase
    end

    alu_addsub #(.W(W)) i_addsub (
        .a    (opnd_a),
        .b    (as_b),
        .cin  (as_cin),
        .sub  (as_sub),
        .sum  (as_sum),
        .cout (as_cout)
    );

    alu_bitwise #(.W(W)) i_bitwise (
        .a   (opnd_a),
        .b   (opnd_b),
        .sel (bw_sel),
        .y   (bw_y)
    );

    alu_shifter #(.W(W)) i_shifter (
        .a    (opnd_a),
        .cin  (c_in),
        .sel  (sh_sel),
        .y    (sh_y),
        .cout (sh_cout)
    );

    alu_flag_logic i_flag_logic (
        .flags (flags_in),
        .mask  (opnd_b[FW-1:0]),
        .sel   (fl_sel),
        .y     (fl_y)
    );

    // next-state computation
    always_comb begin
        logic [W-1:0]  r;
        logic [FW-1:0] f;
        logic          c, z;

        st_d     = st_q;
        st_d.vld = op_valid;

        r = opnd_a;
        c = c_in;
        z = flags_in[FL_ZERO];
        f = flags_in;
        f[FW-1:FL_USED] = '0;

        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_INC: begin
                r = as_sum;
                c = as_cout;
                z = ~|as_sum;
            end
            OP_AND, OP_OR, OP_XOR, OP_CPL: begin
                r = bw_y;
                z = ~|bw_y;
            end
            OP_CMP: begin
                c = as_cout;
                z = ~|as_sum;
            end
            OP_TST: begin
                z = ~|bw_y;
            end
            OP_ASL, OP_ASR, OP_RLC, OP_RRC: begin
                r = sh_y;
                c = sh_cout;
                z = ~|sh_y;
            end
            OP_MOV: begin
                r = opnd_b;
                z = ~|opnd_b;
            end
            default: ;
        endcase

        f[FL_CARRY] = c;
        f[FL_ZERO]  = z;
        if (op == OP_FAND || op == OP_FOR || op == OP_FXOR) begin
            f = fl_y;
        end

        if (op_valid) begin
            st_d.res = r;
            st_d.flg = f;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_out   = st_q.res;
    assign flags_out = st_q.flg;
    assign res_valid = st_q.vld;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
#(
    parameter int W = DW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [OPW-1:0] op_code,
    input logic [W-1:0]  opnd_a,
    input logic [W-1:0]  opnd_b,
    input logic [FW-1:0] flags_in,
    input logic [W-1:0]  res_out,
    input logic [FW-1:0] flags_out,
    input logic          res_valid
);
    logic is_zop, is_keepc, is_keepsel, is_fop;

    assign is_fop     = (op_code == 5'd16) || (op_code == 5'd17) || (op_code == 5'd18);
    assign is_zop     = (op_code <= 5'd6) || ((op_code >= 5'd9) && (op_code <= 5'd15));
    assign is_keepc   = ((op_code >= 5'd4) && (op_code <= 5'd6)) || (op_code == 5'd8)
                      || (op_code == 5'd9) || (op_code == 5'd15) || (op_code >= 5'd19);
    assign is_keepsel = !is_fop;

    // R1: valid follows the request by one cycle
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);
    assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid);

    // R10: outputs hold when idle
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(res_out) && $stable(flags_out)));

    // R9: reserved flag bits always zero after a valid op
    assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (flags_out[FW-1:FL_USED] == '0));

    // R8: supervisor bit never changed by any operation
    assert_super_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (flags_out[FL_SUPER] == $past(flags_in[FL_SUPER])));

    // R9: enable and bank bits pass through outside the flag-byte operations
    assert_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_keepsel) |=> ((flags_out[FL_GIE] == $past(flags_in[FL_GIE]))
                                   && (flags_out[FL_BANK] == $past(flags_in[FL_BANK]))));

    // R4: Carry untouched by Zero-only operations
    assert_carry_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_keepc) |=> (flags_out[FL_CARRY] == $past(flags_in[FL_CARRY])));

    // R2: Zero tracks the produced result for result-writing operations
    assert_zero_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_zop) |=> (flags_out[FL_ZERO] == (res_out == '0)));

    // R5: compare leaves the operand, flags equality and borrow
    assert_cmp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 5'd7) |=> ((res_out == $past(opnd_a))
            && (flags_out[FL_ZERO] == ($past(opnd_a) == $past(opnd_b)))
            && (flags_out[FL_CARRY] == ($past(opnd_a) < $past(opnd_b)))));

    // R6: increment carries only from all-ones
    assert_inc_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 5'd10) |=> (flags_out[FL_CARRY] == ($past(opnd_a) == {W{1'b1}})));

endmodule

bind acc_alu_core acc_alu_chk #(.W(W)) i_acc_alu_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .flags_in  (flags_in),
    .res_out   (res_out),
    .flags_out (flags_out),
    .res_valid (res_valid)
);

// File: tb/test_acc_alu_core.sv
module test_acc_alu_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op_code = '0;
    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_b = '0;
    logic [7:0] flags_in = '0;
    logic [7:0] res_out;
    logic [7:0] flags_out;
    logic       res_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    acc_alu_core i_acc_alu_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .flags_in  (flags_in),
        .res_out   (res_out),
        .flags_out (flags_out),
        .res_valid (res_valid)
    );

    function automatic string req_of(input int op);
        if (op <= 1) return "R2";
        if (op <= 3) return "R3";
        if (op <= 6) return "R4";
        if (op <= 8) return "R5";
        if (op <= 10 || op == 15) return "R6";
        if (op <= 14) return "R7";
        if (op <= 18) return "R8";
        return "R9";
    endfunction

    // Reference model: returns {result, flags}
    function automatic logic [15:0] ref_calc(input int op, input logic [7:0] a,
                                             input logic [7:0] b, input logic [7:0] f);
        logic [8:0] t;
        logic [7:0] r, fo;
        logic       c, z;
        r  = a;
        c  = f[2];
        z  = f[1];
        fo = {3'b000, f[4:0]};
        case (op)
            0:  begin t = {1'b0, a} + {1'b0, b}; r = t[7:0]; c = t[8]; z = (r == 0); end
            1:  begin t = {1'b0, a} + {1'b0, b} + {8'd0, f[2]}; r = t[7:0]; c = t[8]; z = (r == 0); end
            2:  begin r = a - b; c = (a < b); z = (r == 0); end
            3:  begin r = a - b - {7'd0, f[2]}; c = ({1'b0, a} < ({1'b0, b} + {8'd0, f[2]})); z = (r == 0); end
            4:  begin r = a & b; z = (r == 0); end
            5:  begin r = a | b; z = (r == 0); end
            6:  begin r = a ^ b; z = (r == 0); end
            7:  begin c = (a < b); z = (a == b); end
            8:  begin z = ((a & b) == 0); end
            9:  begin r = ~a; z = (r == 0); end
            10: begin r = a + 8'd1; c = (a == 8'hFF); z = (r == 0); end
            11: begin r = {a[6:0], 1'b0}; c = a[7]; z = (r == 0); end
            12: begin r = {a[7], a[7:1]}; c = a[0]; z = (r == 0); end
            13: begin r = {a[6:0], f[2]}; c = a[7]; z = (r == 0); end
            14: begin r = {f[2], a[7:1]}; c = a[0]; z = (r == 0); end
            15: begin r = b; z = (r == 0); end
            default: ;
        endcase
        fo[2] = c;
        fo[1] = z;
        if (op >= 16 && op <= 18) begin
            if (op == 16)      fo = f & b;
            else if (op == 17) fo = f | b;
            else               fo = f ^ b;
            fo[3]   = f[3];
            fo[7:5] = 3'b000;
        end
        return {r, fo};
    endfunction

    task automatic check8(input string req, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input int op, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] f);
        logic [15:0] e;
        e = ref_calc(op, a, b, f);
        @(negedge clk);
        op_code  = op[4:0];
        opnd_a   = a;
        opnd_b   = b;
        flags_in = f;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        check8(req_of(op), $sformatf("res op=%0d", op), res_out, e[15:8]);
        check8(req_of(op), $sformatf("flags op=%0d", op), flags_out, e[7:0]);
        check8("R1", "res_valid after op", {7'd0, res_valid}, 8'd1);
    endtask

    initial begin
        #2ms;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] hr, hf;
        void'($urandom(32'h5EED_0A1B));

        // R1: reset state
        repeat (3) @(negedge clk);
        check8("R1", "reset res", res_out, 8'h00);
        check8("R1", "reset flags", flags_out, 8'h00);
        check8("R1", "reset valid", {7'd0, res_valid}, 8'd0);
        rst_n = 1'b1;

        // directed corners
        do_op(0, 8'hFF, 8'h01, 8'h00);   // R2 wrap to zero with carry
        do_op(1, 8'h7F, 8'h80, 8'h04);   // R2 carry-in makes 0x00
        do_op(1, 8'h10, 8'h20, 8'h00);   // R2
        do_op(2, 8'h00, 8'h01, 8'h00);   // R3 borrow
        do_op(2, 8'h55, 8'h55, 8'h04);   // R3 zero, no borrow
        do_op(3, 8'h00, 8'h00, 8'h04);   // R3 borrow from carry-in
        do_op(3, 8'h05, 8'h04, 8'h04);   // R3 exact zero
        do_op(4, 8'hF0, 8'h0F, 8'h04);   // R4 zero, carry kept set
        do_op(6, 8'hAA, 8'hAA, 8'h00);   // R4
        do_op(7, 8'h33, 8'h33, 8'h04);   // R5 equal
        do_op(7, 8'h10, 8'h20, 8'h00);   // R5 less than
        do_op(8, 8'h0F, 8'hF0, 8'h04);   // R5 test zero
        do_op(9, 8'hFF, 8'h00, 8'h04);   // R6 complement to zero
        do_op(10, 8'hFF, 8'h00, 8'h00);  // R6 increment wrap
        do_op(15, 8'h12, 8'h00, 8'h04);  // R6 move zero
        do_op(11, 8'h80, 8'h00, 8'h00);  // R7
        do_op(12, 8'h81, 8'h00, 8'h00);  // R7 sign kept
        do_op(13, 8'h00, 8'h00, 8'h04);  // R7 carry rotates in
        do_op(14, 8'h01, 8'h00, 8'h00);  // R7 rotate to zero
        do_op(16, 8'h11, 8'h00, 8'h1F);  // R8 clear all except supervisor
        do_op(17, 8'h22, 8'hFF, 8'h00);  // R8 set all except supervisor
        do_op(18, 8'h33, 8'hFF, 8'h08);  // R8 toggle
        do_op(25, 8'h44, 8'h99, 8'hFF);  // R9 unused opcode

        // R10: hold while idle, inputs wiggling
        hr = res_out;
        hf = flags_out;
        @(negedge clk);
        op_code  = 5'd0;
        opnd_a   = 8'h12;
        opnd_b   = 8'h34;
        flags_in = 8'h1F;
        @(negedge clk);
        check8("R10", "held res", res_out, hr);
        check8("R10", "held flags", flags_out, hf);
        check8("R10", "idle valid", {7'd0, res_valid}, 8'd0);

        // random mix
        for (int i = 0; i < 600; i++) begin
            do_op(int'($urandom_range(31, 0)), 8'($urandom), 8'($urandom), 8'($urandom));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule